// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a branch will be taken. It keeps a large table of two-bit saturating counters and one global history register that all branches share. The history records the directions of the most recent conditional branches. A lookup XORs the low address bits of the branch with that history, and the result selects the counter that supplies the prediction. The block therefore follows the habits of each branch and also the patterns that run across neighbouring branches. It holds direction state only. Target addresses are computed elsewhere, and the block stores none.

A fetch stage sends lookups on a valid/ready stream and takes the predictions from a second valid/ready stream one cycle later. Each prediction carries the history snapshot and the table index it used. When the branch resolves, the execute stage sends both back on the update port with the real outcome and a flag that says whether the prediction was wrong. Back-pressure works as follows. `lk_ready` is low while the table is being initialised. It is also low while a response is held and `rs_ready` is low, and in the cycle a conditional misprediction update is presented. `up_ready` is low only during initialisation. A response stays stable until it is accepted.

Top module: `bdir_predictor`

## Requirements
- R1: After reset the block spends 2^IDX_W cycles setting every counter to 01 (weakly not-taken). During that time `lk_ready` and `up_ready` are low, so the first conditional lookup after initialisation predicts not-taken.
- R2: A lookup uses the index `lk_addr XOR ghr`, where `ghr` is the history before the lookup. The response returns this index on `rs_idx` and the history on `rs_hist`.
- R3: Each counter is 2 bits wide and predicts taken when its value is 2 or 3. A conditional update adds one on taken and subtracts one on not-taken. It holds at 3 and at 0 and never wraps.
- R4: An unconditional lookup (`lk_uncond`=1) is always predicted taken and leaves the history unchanged. An update with `up_uncond`=1 changes neither the counters nor the history.
- R5: An accepted conditional lookup shifts its predicted direction into the history LSB: `ghr <= {ghr[IDX_W-2:0], pred}`.
- R6: An accepted conditional update with `up_mispred`=1 sets `ghr <= {up_hist[IDX_W-2:0], up_taken}`. In that cycle `lk_ready` is low.
- R7: The response for a lookup accepted at one edge appears with `rs_valid` high right after that edge.
- R8: When a conditional update and a lookup hit the same index in the same cycle, the lookup predicts from the counter value after the update.
- R9: While `rs_valid`=1 and `rs_ready`=0, the response fields stay stable and `lk_ready` is low.
- R10: After initialisation `up_ready` is high in every cycle, and one update is accepted per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_addr | input | IDX_W | Low address bits of the branch |
| lk_uncond | input | 1 | 1 = unconditional branch |
| rs_valid | output | 1 | Prediction valid |
| rs_ready | input | 1 | Consumer takes prediction |
| rs_taken | output | 1 | Predicted direction, 1 = taken |
| rs_idx | output | IDX_W | Table index the lookup used |
| rs_hist | output | IDX_W | History snapshot before the lookup |
| up_valid | input | 1 | Resolved-branch update valid |
| up_ready | output | 1 | Update accepted when high with up_valid |
| up_idx | input | IDX_W | Index returned by the lookup |
| up_hist | input | IDX_W | History snapshot returned by the lookup |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_mispred | input | 1 | 1 = prediction was wrong |
| up_uncond | input | 1 | 1 = unconditional branch, update ignored |

## Verification
The bench walks one counter up into saturation and back down to saturation. A counter that wraps would flip a strongly taken entry to not-taken. It sends a misprediction restore together with a lookup, which a design that shifted the stale history would corrupt. It also sends an update and a lookup to the same index in one cycle, where a missing bypass shows up as a stale not-taken. Unconditional traffic on both ports shows whether the history or the counters move when they must not. Held responses under `rs_ready`=0 catch a response register that is overwritten, and a long random phase with heavy index aliasing is checked against the behavioural model on every cycle.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;
  localparam ctr_t CTR_MAX     = 2'b11;
  localparam ctr_t CTR_MIN     = 2'b00;

  // saturating step of one direction counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == CTR_MAX) ? CTR_MAX : ctr_t'(cur + 2'd1);
    else       nxt = (cur == CTR_MIN) ? CTR_MIN : ctr_t'(cur - 2'd1);
    return nxt;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bdp_hash.sv
module bdp_hash #(
  parameter int IDX_W = 13
) (
  input  logic [IDX_W-1:0] addr,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx
);

  // per-bit mix of address and shared history
  for (genvar b = 0; b < IDX_W; b++) begin : g_mix
    assign idx[b] = addr[b] ^ hist[b];
  end

endmodule

// File: rtl/bdp_ghr.sv
module bdp_ghr #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_bit,
  input  logic         restore_en,
  input  logic [W-1:0] restore_hist,
  input  logic         restore_bit,
  output logic [W-1:0] ghr
);

  logic [W-1:0] ghr_nxt;

  always_comb begin
    ghr_nxt = ghr;
    if (restore_en)    ghr_nxt = {restore_hist[W-2:0], restore_bit};
    else if (shift_en) ghr_nxt = {ghr[W-2:0], shift_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghr <= '0;
    else        ghr <= ghr_nxt;
  end

  // R5: speculative shift moves history up by one
  a_r5_shift_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !restore_en) |=> (ghr[0] == $past(shift_bit)) &&
                                  (ghr[W-1:1] == $past(ghr[W-2:0])));

  // R6: restore rebuilds history from checkpoint
  a_r6_restore: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> (ghr[W-1:1] == $past(restore_hist[W-2:0])) &&
                   (ghr[0] == $past(restore_bit)));

  a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !restore_en) |=> $stable(ghr));

endmodule

// File: rtl/bdp_table.sv
module bdp_table
  import bdp_pkg::*;
#(
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             busy,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  ctr_t             cnt [ENTRIES];
  logic [IDX_W-1:0] sweep_ptr;
  ctr_t             wr_old;
  ctr_t             wr_new;

  assign wr_old = cnt[wr_idx];
  assign wr_new = ctr_step(wr_old, wr_taken);

  // sweep pointer walks all entries once after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b1;
      sweep_ptr <= '0;
    end else if (busy) begin
      sweep_ptr <= sweep_ptr + 1'b1;
      if (sweep_ptr == LAST) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (busy)        cnt[sweep_ptr] <= CTR_WEAK_NT;
    else if (wr_en)  cnt[wr_idx]    <= wr_new;
  end

  // write-to-read bypass for a colliding lookup
  always_comb begin
    if (wr_en && !busy && (wr_idx == rd_idx)) rd_ctr = wr_new;
    else                                      rd_ctr = cnt[rd_idx];
  end

  // checker state for saturation properties
  logic             chk_vld;
  logic [IDX_W-1:0] chk_idx;
  ctr_t             chk_old;
  logic             chk_tk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld <= 1'b0;
      chk_idx <= '0;
      chk_old <= CTR_MIN;
      chk_tk  <= 1'b0;
    end else begin
      chk_vld <= wr_en && !busy;
      chk_idx <= wr_idx;
      chk_old <= wr_old;
      chk_tk  <= wr_taken;
    end
  end

  a_r3_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && chk_tk && chk_old == CTR_MAX) |-> (cnt[chk_idx] == CTR_MAX));

  a_r3_hold_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld && !chk_tk && chk_old == CTR_MIN) |-> (cnt[chk_idx] == CTR_MIN));

  a_r1_busy_once: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);

endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor
  import bdp_pkg::*;
#(
  parameter int IDX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [IDX_W-1:0] lk_addr,
  input  logic             lk_uncond,
  output logic             rs_valid,
  input  logic             rs_ready,
  output logic             rs_taken,
  output logic [IDX_W-1:0] rs_idx,
  output logic [IDX_W-1:0] rs_hist,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [IDX_W-1:0] up_idx,
  input  logic [IDX_W-1:0] up_hist,
  input  logic             up_taken,
  input  logic             up_mispred,
  input  logic             up_uncond
);

  logic             init_busy;
  logic [IDX_W-1:0] ghr;
  logic [IDX_W-1:0] lk_idx;
  ctr_t             lk_ctr;
  logic             lk_pred;
  logic             lk_fire;
  logic             up_fire;
  logic             up_cond_fire;
  logic             restore_req;
  logic             restore_en;
  logic             rs_free;

  // handshake decisions
  assign restore_req  = up_valid && up_mispred && !up_uncond;
  assign rs_free      = !rs_valid || rs_ready;
  assign up_ready     = !init_busy;
  assign lk_ready     = !init_busy && !restore_req && rs_free;
  assign lk_fire      = lk_valid && lk_ready;
  assign up_fire      = up_valid && up_ready;
  assign up_cond_fire = up_fire && !up_uncond;
  assign restore_en   = up_cond_fire && up_mispred;

  bdp_hash #(.IDX_W(IDX_W)) u_hash (
    .addr (lk_addr),
    .hist (ghr),
    .idx  (lk_idx)
  );

  bdp_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (init_busy),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (up_cond_fire),
    .wr_idx   (up_idx),
    .wr_taken (up_taken)
  );

  assign lk_pred = lk_uncond ? 1'b1 : ctr_says_taken(lk_ctr);

  bdp_ghr #(.W(IDX_W)) u_ghr (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_en     (lk_fire && !lk_uncond),
    .shift_bit    (lk_pred),
    .restore_en   (restore_en),
    .restore_hist (up_hist),
    .restore_bit  (up_taken),
    .ghr          (ghr)
  );

  // response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_taken <= 1'b0;
      rs_idx   <= '0;
      rs_hist  <= '0;
    end else if (lk_fire) begin
      rs_valid <= 1'b1;
      rs_taken <= lk_pred;
      rs_idx   <= lk_idx;
      rs_hist  <= ghr;
    end else if (rs_ready) begin
      rs_valid <= 1'b0;
    end
  end

  a_r1_init_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    init_busy |-> (!lk_ready && !up_ready));

  a_r4_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && lk_uncond) |=> (rs_valid && rs_taken));

  a_r4_uncond_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fire && lk_uncond) |=> $stable(ghr));

  a_r6_stall_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_mispred && !up_uncond) |-> !lk_ready);

  a_r7_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> rs_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_taken) &&
                                 $stable(rs_idx) && $stable(rs_hist)));

  a_r10_up_open: assert property (@(posedge clk) disable iff (!rst_n)
    !init_busy |-> up_ready);

endmodule

// File: tb/bdir_predictor_bench.sv
module bdir_predictor_bench;

  localparam int IDX_W   = 13;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int WD_CYC  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             lk_valid, lk_ready, lk_uncond;
  logic [IDX_W-1:0] lk_addr;
  logic             rs_valid, rs_ready, rs_taken;
  logic [IDX_W-1:0] rs_idx, rs_hist;
  logic             up_valid, up_ready, up_taken, up_mispred, up_uncond;
  logic [IDX_W-1:0] up_idx, up_hist;

  bdir_predictor #(.IDX_W(IDX_W)) u_bdir_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr), .lk_uncond(lk_uncond),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_taken(rs_taken),
    .rs_idx(rs_idx), .rs_hist(rs_hist),
    .up_valid(up_valid), .up_ready(up_ready), .up_idx(up_idx), .up_hist(up_hist),
    .up_taken(up_taken), .up_mispred(up_mispred), .up_uncond(up_uncond)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model
  logic [1:0]       m_cnt [ENTRIES];
  logic [IDX_W-1:0] m_ghr = '0;
  int               m_init = ENTRIES - 1;
  logic             m_rs_v = 0, m_rs_t = 0;
  logic [IDX_W-1:0] m_rs_i = '0, m_rs_h = '0;

  // staged stimulus
  logic             n_lv = 0, n_lu = 0, n_rr = 1;
  logic [IDX_W-1:0] n_la = '0;
  logic             n_uv = 0, n_ut = 0, n_um = 0, n_uu = 0;
  logic [IDX_W-1:0] n_ui = '0, n_uh = '0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    logic       e_lr, e_ur, lfire, ufire;
    logic [1:0] c;
    logic [IDX_W-1:0] li;
    @(negedge clk);
    lk_valid = n_lv; lk_addr = n_la; lk_uncond = n_lu; rs_ready = n_rr;
    up_valid = n_uv; up_idx = n_ui; up_hist = n_uh; up_taken = n_ut;
    up_mispred = n_um; up_uncond = n_uu;
    #1;
    chk("R7 rs_valid", rs_valid, m_rs_v);
    if (m_rs_v) begin
      chk("R3 rs_taken", rs_taken, m_rs_t);
      chk("R2 rs_idx", rs_idx, m_rs_i);
      chk("R5 rs_hist", rs_hist, m_rs_h);
    end
    e_ur = (m_init == 0);
    e_lr = e_ur && !(n_uv && n_um && !n_uu) && (!m_rs_v || n_rr);
    chk("R1 R6 R9 lk_ready", lk_ready, e_lr);
    chk("R1 R10 up_ready", up_ready, e_ur);
    lfire = n_lv && e_lr;
    ufire = n_uv && e_ur;
    li = n_la ^ m_ghr;
    if (ufire && !n_uu) begin
      c = m_cnt[n_ui];
      if (n_ut) m_cnt[n_ui] = (c == 3) ? 2'd3 : c + 2'd1;
      else      m_cnt[n_ui] = (c == 0) ? 2'd0 : c - 2'd1;
    end
    if (lfire) begin
      m_rs_v = 1;
      m_rs_t = n_lu ? 1'b1 : m_cnt[li][1];
      m_rs_i = li;
      m_rs_h = m_ghr;
    end else if (n_rr) m_rs_v = 0;
    if (ufire && !n_uu && n_um) m_ghr = {n_uh[IDX_W-2:0], n_ut};
    else if (lfire && !n_lu)    m_ghr = {m_ghr[IDX_W-2:0], m_rs_t};
    if (m_init > 0) m_init--;
  endtask

  task automatic idle();
    n_lv = 0; n_uv = 0; n_rr = 1;
  endtask

  task automatic look(input logic [IDX_W-1:0] a, input logic u);
    n_lv = 1; n_la = a; n_lu = u;
  endtask

  task automatic upd(input logic [IDX_W-1:0] i, input logic t, input logic m, input logic u,
                     input logic [IDX_W-1:0] h);
    n_uv = 1; n_ui = i; n_ut = t; n_um = m; n_uu = u; n_uh = h;
  endtask

  initial begin
    #(WD_CYC * 8);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [IDX_W-1:0] h0;
    for (int i = 0; i < ENTRIES; i++) m_cnt[i] = 2'b01;
    lk_valid = 0; lk_addr = '0; lk_uncond = 0; rs_ready = 1;
    up_valid = 0; up_idx = '0; up_hist = '0; up_taken = 0; up_mispred = 0; up_uncond = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset rs_valid", rs_valid, 0);
    rst_n = 1;
    // R1: initialisation with requests pending, readies must stay low
    look(13'h005, 0); upd(13'h005, 1, 0, 0, '0);
    for (int k = 0; k < ENTRIES - 1; k++) tick();
    idle(); tick(); tick();

    // R1 R2: first lookup predicts weakly not-taken entry
    look(13'h005, 0); tick(); idle(); tick();
    chk("R1 first prediction", rs_taken, 0);
    chk("R2 first index", rs_idx, 13'h005);

    // R3: count up into saturation, one step down stays taken
    for (int k = 0; k < 4; k++) begin upd(13'h005, 1, 0, 0, '0); tick(); end
    upd(13'h005, 0, 0, 0, '0); tick(); idle();
    look(13'h005 ^ m_ghr, 0); tick(); idle(); tick();
    chk("R3 saturated high", rs_taken, 1);
    // R3: drive to the bottom and past it
    for (int k = 0; k < 5; k++) begin upd(13'h005, 0, 0, 0, '0); tick(); end
    upd(13'h005, 1, 0, 0, '0); tick(); idle();
    look(13'h005 ^ m_ghr, 0); tick(); idle(); tick();
    chk("R3 saturated low", rs_taken, 0);

    // R4: unconditional lookup is taken and leaves history alone
    h0 = m_ghr;
    look(13'h123, 1); tick(); idle(); tick();
    chk("R4 uncond taken", rs_taken, 1);
    look(13'h000, 0); tick(); idle(); tick();
    chk("R4 history unchanged", rs_hist, h0);
    // R4: unconditional updates are ignored
    for (int k = 0; k < 3; k++) begin upd(13'h040, 1, 1, 1, 13'h1FFF); tick(); end
    idle(); h0 = m_ghr;
    look(13'h040 ^ m_ghr, 0); tick(); idle(); tick();
    chk("R4 counter untouched", rs_taken, 0);
    chk("R4 history untouched", rs_hist, h0);

    // R6: restore with a lookup waiting
    upd(13'h077, 1, 1, 0, 13'h0AB); look(13'h001, 0); tick();
    n_uv = 0; tick(); idle(); tick();
    chk("R6 restored history", rs_hist, 13'h0157);

    // R8: update and lookup to the same entry in one cycle
    upd(13'h0200, 1, 0, 0, '0); look(13'h0200 ^ m_ghr, 0); tick(); idle(); tick();
    chk("R8 bypassed prediction", rs_taken, 1);

    // R9: back-pressure holds the response
    look(13'h0300, 0); n_rr = 0;
    for (int k = 0; k < 5; k++) tick();
    n_rr = 1; tick(); idle(); tick();

    // random phase with heavy aliasing
    for (int k = 0; k < 4000; k++) begin
      n_lv = ($urandom_range(0, 3) != 0);
      n_la = IDX_W'($urandom_range(0, 15));
      n_lu = ($urandom_range(0, 7) == 0);
      n_rr = ($urandom_range(0, 4) != 0);
      n_uv = ($urandom_range(0, 1) == 1);
      n_ui = IDX_W'($urandom_range(0, 15));
      n_uh = IDX_W'($urandom);
      n_ut = ($urandom_range(0, 2) != 0);
      n_um = ($urandom_range(0, 9) == 0);
      n_uu = ($urandom_range(0, 9) == 0);
      tick();
    end
    idle(); tick(); tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule